// File: doc/BRIEF.md
# Sleep-Aware Key Matrix Scanner

This block reads a 12-column by 6-row switch matrix. Its rows are pulled high and its columns are driven through open-drain outputs. At rest it holds every column low, so a press on any key pulls a row low and wakes the block. Once awake, it drives one column at a time and waits a settling interval before it samples the six rows. The inverted row pattern of each column goes into one slot of a twelve-slot scan image.

Full scans start at a fixed period. A scan image is accepted only when it matches the scan taken just before it. An accepted image is published with a one-cycle valid strobe, and a separate one-cycle pulse marks an image that differs from the one already shown. A scan that finds no key pressed publishes an empty image and returns the block to rest. Settle time and period are given in microseconds and counted with microsecond ticks derived from the clock frequency parameter. Row inputs pass through a two-flop synchronizer before any use.

Top module: `keymatrix_scanner`

## Requirements
- R1: While asleep (awake_o = 0), all bits of col_drive_o are 1, meaning every column is pulled low. After reset the block is asleep, keys_o is all zero, and valid_o and update_o are 0.
- R2: While asleep, any row_i bit at 0 wakes the block: awake_o goes to 1 within three clock cycles.
- R3: While awake, at most one col_drive_o bit is 1. Between scans every column is released (all bits 0).
- R4: Each scan drives the columns in order, index 0 up to NCOL-1. Each column is driven for exactly SETTLE_US microseconds (SETTLE_US*CLK_HZ/1e6 cycles) and is sampled in the last cycle of that interval.
- R5: In an accepted image, keys_o[c][r] is 1 exactly when the key at column c, row r is pressed, that is, when row_i[r] reads 0 while only column c is driven.
- R6: Consecutive scans within one awake session start exactly PERIOD_US microseconds apart.
- R7: A non-empty scan is accepted only when it equals the previous scan of the same awake session. Acceptance raises valid_o for one cycle. The first valid after a wake comes 1 + PERIOD_CYC + NCOL*SETTLE_CYC cycles after awake_o rises.
- R8: A scan with no key pressed publishes an all-zero keys_o with a valid_o pulse and returns the block to sleep in the same cycle.
- R9: update_o pulses together with valid_o only when the published image differs from the previous keys_o.
- R10: keys_o changes only in a cycle where valid_o is 1. While scans keep differing, nothing is published.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_i | input | NROW | Raw row lines, 0 = pulled low by a pressed key |
| col_drive_o | output | NCOL | Per-column drive enable, 1 = pull column low, 0 = high impedance |
| keys_o | output | NCOL*NROW | Published image, keys_o[c][r] = 1 when pressed |
| valid_o | output | 1 | One-cycle strobe when an image is published |
| update_o | output | 1 | One-cycle strobe when the published image changed |
| awake_o | output | 1 | 1 while scanning, 0 while asleep with all columns low |

## Verification
All 72 single-key positions are swept, one at a time. This separates every column slot and row bit, so a swapped column order, a wrong row bit or a missing inversion shows up at a distinct position. Multi-key images follow: a full matrix, a full column, a full row, a diagonal and a checkerboard. These show that rows sharing a column and columns sharing a row are captured independently. A pattern that alternates between two images on every scan shows that unequal consecutive scans never publish. A steady image then shows that debouncing resumes, and that repeated equal images do not raise update_o. Releasing every key exercises the return to sleep. The column timing, order and period are measured on every scan.

// File: rtl/kms_pkg.sv
package kms_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EVAL = 2'd2,
    ST_WAIT = 2'd3
  } kms_state_e;
endpackage

// File: rtl/kms_sync.sv
module kms_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  // reset to idle-high: rows are pulled up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/kms_tick.sv
module kms_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/kms_ctrl.sv
module kms_ctrl
  import kms_pkg::*;
#(
  parameter int unsigned NCOL      = 12,
  parameter int unsigned NROW      = 6,
  parameter int unsigned SETTLE_US = 10,
  parameter int unsigned PERIOD_US = 5000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NROW-1:0]           row_n_i,
  input  logic                      col_tick_i,
  input  logic                      per_tick_i,
  output logic                      clr_col_o,
  output logic                      clr_per_o,
  output logic [NCOL-1:0]           col_drive_o,
  output logic                      awake_o,
  output logic                      done_o,
  output logic [NCOL-1:0][NROW-1:0] scan_o
);
  localparam int unsigned CW = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int unsigned SW = (SETTLE_US > 1) ? $clog2(SETTLE_US) : 1;
  localparam int unsigned PW = (PERIOD_US > 1) ? $clog2(PERIOD_US) : 1;

  kms_state_e               state_q;
  logic [CW-1:0]            col_idx_q;
  logic [SW-1:0]            set_cnt_q;
  logic [PW-1:0]            per_cnt_q;
  logic [NCOL-1:0][NROW-1:0] scan_q;
  logic                     sample, restart;

  assign sample  = (state_q == ST_SCAN) && col_tick_i && (set_cnt_q == SW'(SETTLE_US - 1));
  assign restart = (state_q == ST_WAIT) && per_tick_i && (per_cnt_q == PW'(PERIOD_US - 1));

  // settle prescaler restarts per column, period prescaler per scan
  assign clr_col_o = (state_q != ST_SCAN) || sample;
  assign clr_per_o = (state_q == ST_IDLE) || restart;
  assign awake_o   = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_EVAL);
  assign scan_o    = scan_q;

  always_comb begin
    col_drive_o = '0;
    unique case (state_q)
      ST_IDLE: col_drive_o = '1;
      ST_SCAN: col_drive_o[col_idx_q] = 1'b1;
      default: col_drive_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_cnt_q <= '0;
      per_cnt_q <= '0;
    end else begin
      if (clr_col_o)       set_cnt_q <= '0;
      else if (col_tick_i) set_cnt_q <= set_cnt_q + 1'b1;
      if (clr_per_o)       per_cnt_q <= '0;
      else if (per_tick_i) per_cnt_q <= per_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      col_idx_q <= '0;
      scan_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (row_n_i != '1) begin
          state_q   <= ST_SCAN;
          col_idx_q <= '0;
        end
        ST_SCAN: if (sample) begin
          scan_q[col_idx_q] <= ~row_n_i;
          if (col_idx_q == CW'(NCOL - 1)) begin
            state_q   <= ST_EVAL;
            col_idx_q <= '0;
          end else begin
            col_idx_q <= col_idx_q + 1'b1;
          end
        end
        ST_EVAL: state_q <= (scan_q == '0) ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (restart) state_q <= ST_SCAN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kms_debounce.sv
module kms_debounce #(
  parameter int unsigned NCOL = 12,
  parameter int unsigned NROW = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      awake_i,
  input  logic                      done_i,
  input  logic [NCOL-1:0][NROW-1:0] scan_i,
  output logic [NCOL-1:0][NROW-1:0] keys_o,
  output logic                      valid_o,
  output logic                      update_o
);
  logic [NCOL-1:0][NROW-1:0] prev_q;
  logic                      have_prev_q;
  logic                      empty, match;

  assign empty = (scan_i == '0);
  assign match = have_prev_q && (scan_i == prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      keys_o      <= '0;
      valid_o     <= 1'b0;
      update_o    <= 1'b0;
    end else begin
      valid_o  <= 1'b0;
      update_o <= 1'b0;
      if (!awake_i) have_prev_q <= 1'b0;
      if (done_i) begin
        prev_q      <= scan_i;
        have_prev_q <= !empty;
        // empty scan publishes at once so sleep never leaves stale keys
        if (empty || match) begin
          keys_o   <= scan_i;
          valid_o  <= 1'b1;
          update_o <= (scan_i != keys_o);
        end
      end
    end
  end
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner #(
  parameter int unsigned NCOL      = 12,
  parameter int unsigned NROW      = 6,
  parameter int unsigned CLK_HZ    = 2_000_000,
  parameter int unsigned SETTLE_US = 10,
  parameter int unsigned PERIOD_US = 5000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NROW-1:0]           row_i,
  output logic [NCOL-1:0]           col_drive_o,
  output logic [NCOL-1:0][NROW-1:0] keys_o,
  output logic                      valid_o,
  output logic                      update_o,
  output logic                      awake_o
);
  localparam int unsigned US_DIV = (CLK_HZ >= 2_000_000) ? CLK_HZ / 1_000_000 : 1;

  logic [NROW-1:0]           row_n_s;
  logic                      col_tick, per_tick, clr_col, clr_per, done;
  logic [NCOL-1:0][NROW-1:0] scan;

  kms_sync #(.W(NROW)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(row_i), .q_o(row_n_s)
  );

  kms_tick #(.DIV(US_DIV)) u_col_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_col), .tick_o(col_tick)
  );

  kms_tick #(.DIV(US_DIV)) u_per_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_per), .tick_o(per_tick)
  );

  kms_ctrl #(
    .NCOL(NCOL), .NROW(NROW), .SETTLE_US(SETTLE_US), .PERIOD_US(PERIOD_US)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .row_n_i(row_n_s),
    .col_tick_i(col_tick), .per_tick_i(per_tick),
    .clr_col_o(clr_col), .clr_per_o(clr_per),
    .col_drive_o(col_drive_o), .awake_o(awake_o),
    .done_o(done), .scan_o(scan)
  );

  kms_debounce #(.NCOL(NCOL), .NROW(NROW)) u_debounce (
    .clk_i(clk_i), .rst_ni(rst_ni), .awake_i(awake_o), .done_i(done),
    .scan_i(scan), .keys_o(keys_o), .valid_o(valid_o), .update_o(update_o)
  );
endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int unsigned NCOL = 12,
  parameter int unsigned NROW = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NCOL-1:0]           col_drive_o,
  input logic [NCOL-1:0][NROW-1:0] keys_o,
  input logic                      valid_o,
  input logic                      update_o,
  input logic                      awake_o
);
  // R1
  idle_cols_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_o |-> (col_drive_o == '1));

  // R3
  single_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake_o |-> $onehot0(col_drive_o));

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R9
  update_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> valid_o);

  // R10
  keys_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(keys_o) |-> valid_o);

  // R8
  sleep_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(awake_o) |-> (valid_o && keys_o == '0));
endmodule

bind keymatrix_scanner kms_checker #(.NCOL(NCOL), .NROW(NROW)) u_kms_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .col_drive_o(col_drive_o), .keys_o(keys_o),
  .valid_o(valid_o), .update_o(update_o), .awake_o(awake_o)
);

// File: tb/keymatrix_scanner_bench.sv
module keymatrix_scanner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL       = 12;
  localparam int NROW       = 6;
  localparam int CLK_HZ     = 4_000_000;
  localparam int SETTLE_US  = 2;
  localparam int PERIOD_US  = 50;
  localparam int DIV        = CLK_HZ / 1_000_000;
  localparam int SETTLE_CYC = SETTLE_US * DIV;
  localparam int PERIOD_CYC = PERIOD_US * DIV;
  localparam int FIRST_GAP  = 1 + PERIOD_CYC + NCOL * SETTLE_CYC;

  typedef logic [NCOL-1:0][NROW-1:0] img_t;

  logic            clk, rst_n;
  logic [NROW-1:0] row;
  logic [NCOL-1:0] col_drive;
  img_t            keys, pressed;
  logic            valid, update, awake;

  int n_tests = 0, n_fail = 0;

  keymatrix_scanner #(
    .NCOL(NCOL), .NROW(NROW), .CLK_HZ(CLK_HZ),
    .SETTLE_US(SETTLE_US), .PERIOD_US(PERIOD_US)
  ) u_keymatrix_scanner (
    .clk_i(clk), .rst_ni(rst_n), .row_i(row), .col_drive_o(col_drive),
    .keys_o(keys), .valid_o(valid), .update_o(update), .awake_o(awake)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // matrix model: a row is low when a driven column has a pressed key on it
  always_comb begin
    for (int r = 0; r < NROW; r++) begin
      row[r] = 1'b1;
      for (int c = 0; c < NCOL; c++)
        if (col_drive[c] && pressed[c][r]) row[r] = 1'b0;
    end
  end

  // port monitor
  int cyc = 0, valid_cnt = 0, wake_cyc = 0, last_valid_cyc = 0;
  int run = 0, last_idx = 0, last_start = 0;
  int err_idle = 0, err_onehot = 0, err_settle = 0, err_order = 0, err_period = 0;
  int scans = 0;
  bit last_upd = 0, have_start = 0, prev_awake = 0;
  logic [NCOL-1:0] prev_cd = '1;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (awake && !prev_awake) wake_cyc = cyc;
      if (!awake) have_start = 0;
      if (valid) begin valid_cnt++; last_upd = update; last_valid_cyc = cyc; end
      if (!awake && col_drive != '1) err_idle++;
      if (awake && $countones(col_drive) > 1) err_onehot++;
      if (col_drive != prev_cd) begin
        if ($countones(prev_cd) == 1 && run != SETTLE_CYC) err_settle++;
        if ($countones(col_drive) == 1) begin
          int idx = 0;
          for (int c = 0; c < NCOL; c++) if (col_drive[c]) idx = c;
          if (idx != 0 && idx != last_idx + 1) err_order++;
          if (idx == 0 && $countones(prev_cd) == 1) err_order++;
          if (idx == 0) begin
            if (have_start && cyc - last_start != PERIOD_CYC) err_period++;
            have_start = 1;
            last_start = cyc;
            scans++;
          end
          last_idx = idx;
        end
        run = 1;
      end else begin
        run++;
      end
      prev_cd = col_drive;
      prev_awake = awake;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got);
    int base = valid_cnt;
    got = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (valid_cnt != base) begin got = 1; break; end
    end
  endtask

  task automatic wait_sleep(output bit got);
    got = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (!awake) begin got = 1; break; end
    end
  endtask

  task automatic press_case(input img_t pat, input bit full);
    bit got;
    pressed = pat;
    repeat (4) @(negedge clk);
    #1;
    chk(awake, "R2", "wake after press", 72'(awake), 72'(1));
    wait_valid(got);
    chk(got && keys == pat, "R5", "accepted image", keys, pat);
    chk(last_upd, "R9", "update on change", 72'(last_upd), 72'(1));
    if (full) begin
      chk(last_valid_cyc - wake_cyc == FIRST_GAP, "R7", "first valid delay",
          72'(last_valid_cyc - wake_cyc), 72'(FIRST_GAP));
      wait_valid(got);
      chk(got && keys == pat && !last_upd, "R9", "repeat image no update",
          {keys[NCOL-1:1], 5'd0, last_upd}, {pat[NCOL-1:1], 6'd0});
    end
    pressed = '0;
    wait_sleep(got);
    chk(got && keys == '0, "R8", "release to sleep", keys, 72'(0));
    #1;
    chk(col_drive == '1, "R1", "columns low asleep", 72'(col_drive), 72'hfff);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    img_t p;
    bit got;
    int vbase, sbase;
    pressed = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!awake && col_drive == '1 && keys == '0 && !valid && !update, "R1",
        "reset state", {col_drive, awake, valid, update}, {12'hfff, 3'b000});
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    chk(!awake && valid_cnt == 0, "R1", "stays asleep with no key",
        72'(awake), 72'(0));

    // R5 single-key sweep over every position
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++) begin
        p = '0; p[c][r] = 1'b1;
        press_case(p, (c == 0 && r == 0) || (c == NCOL-1 && r == NROW-1));
      end

    // R5 multi-key images
    press_case('1, 1);
    p = '0; p[3] = '1; press_case(p, 1);
    p = '0; for (int c = 0; c < NCOL; c++) p[c][2] = 1'b1; press_case(p, 1);
    p = '0; for (int c = 0; c < NCOL; c++) p[c][c % NROW] = 1'b1; press_case(p, 1);
    p = '0;
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++) p[c][r] = ((c + r) % 2 == 0);
    press_case(p, 1);

    // R10 alternating images must never publish
    p = '0; p[5][1] = 1'b1;
    pressed = p;
    wait_valid(got);
    chk(got && keys == p, "R7", "baseline accepted", keys, p);
    sbase = scans;
    while (scans == sbase) @(negedge clk);
    repeat (150) @(negedge clk);
    pressed = '0; pressed[1][4] = 1'b1;
    vbase = valid_cnt;
    for (int k = 0; k < 6; k++) begin
      sbase = scans;
      while (scans == sbase) @(negedge clk);
      repeat (150) @(negedge clk);
      pressed = '0;
      if (k % 2 == 0) pressed[9][0] = 1'b1; else pressed[1][4] = 1'b1;
    end
    #1;
    chk(valid_cnt == vbase && keys == p, "R10", "bouncing not published",
        72'(valid_cnt - vbase), 72'(0));
    wait_valid(got);
    chk(got && keys == pressed && last_upd, "R7", "steady after bounce", keys, pressed);
    pressed = '0;
    wait_sleep(got);
    chk(got && keys == '0, "R8", "sleep after bounce", keys, 72'(0));

    repeat (10) @(negedge clk);
    chk(err_idle == 0, "R1", "idle drive errors", 72'(err_idle), 72'(0));
    chk(err_onehot == 0, "R3", "multi-column drive", 72'(err_onehot), 72'(0));
    chk(err_settle == 0, "R4", "column settle length", 72'(err_settle), 72'(0));
    chk(err_order == 0, "R4", "column order", 72'(err_order), 72'(0));
    chk(err_period == 0, "R6", "scan period", 72'(err_period), 72'(0));
    chk(scans > 100, "R6", "scans observed", 72'(scans), 72'(101));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule